// File: doc/BRIEF.md
# Audio Master Clock Divider Unit

This block produces the two timing clocks of an audio converter serial port, the bit clock and the frame (left/right) clock, from one master clock. A ratio select picks whether the master clock runs at 256 or 384 times the sample rate. In both settings the bit clock runs at 64 times the frame rate. Each half frame therefore holds 32 bit slots.

A role select decides where the clocks come from. As clock master, the block divides the master clock itself. The bit clock gets a 50 % duty cycle, and every frame clock transition lands on a falling edge of the bit clock. As clock slave, the external bit and frame clocks are routed straight to the outputs. Both roles also give single-cycle strobes in the master clock domain for use by neighbouring logic. In slave mode the strobes come from a synchronizer.

All pins are plain level signals: no data stream crosses this block, so there is no valid/ready handshake. Any change on either select restarts the dividers from a known phase.

Top module: `audio_clk_div`

## Requirements
- R1: While `rst_n` is low, `bclk`, `lrclk` and all four strobes are 0.
- R2: Master mode with `ratio_sel`=0: `bclk` has a period of 4 master cycles (2 high, 2 low) and `lrclk` has a period of 256 master cycles.
- R3: Master mode with `ratio_sel`=1: `bclk` has a period of 6 master cycles (3 high, 3 low) and `lrclk` has a period of 384 master cycles.
- R4: In master mode `lrclk` changes level after every 32 `bclk` periods, so one `lrclk` period contains exactly 64 rising edges of `bclk`.
- R5: In master mode each `lrclk` transition occurs in the same master cycle as a falling edge of `bclk`.
- R6: In master mode `bclk_rise_stb` is high for exactly the first cycle in which `bclk` is 1. `bclk_fall_stb` is high for exactly the first cycle in which `bclk` is 0. `lr_edge_stb` is high in the first cycle after any `lrclk` transition. `frame_stb` is high only in the first cycle after a 1-to-0 transition of `lrclk`, which marks the start of a frame.
- R7: When `ratio_sel` or `master_en` differs from its value in the previous cycle, both generated clocks are 0 in the next cycle. `lrclk` then stays 0 for exactly 128 (`ratio_sel`=0) or 192 (`ratio_sel`=1) master cycles before its first rise.
- R8: In slave mode (`master_en`=0), `bclk` equals `ext_bclk` and `lrclk` equals `ext_lrclk` with no register in the path.
- R9: In slave mode each edge of `ext_bclk` or `ext_lrclk` gives exactly one single-cycle pulse on the matching strobe, at most 4 master cycles after the edge. The strobe follows the R6 encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ratio_sel | input | 1 | 0: master/frame ratio 256, 1: ratio 384 |
| master_en | input | 1 | 1: generate clocks, 0: pass external clocks |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_lrclk | input | 1 | External frame clock (slave mode) |
| bclk | output | 1 | Bit clock |
| lrclk | output | 1 | Frame clock |
| bclk_rise_stb | output | 1 | Strobe on bit clock rising edge |
| bclk_fall_stb | output | 1 | Strobe on bit clock falling edge |
| lr_edge_stb | output | 1 | Strobe on each frame clock transition |
| frame_stb | output | 1 | Strobe on frame clock falling edge (frame start) |

## Verification
The embedded properties check every cycle in master mode. They check that each half period of the bit clock and of the frame clock has the length set by the current ratio, that frame transitions sit on bit clock falling edges, that each strobe matches the clock edge it reports, and that the generated clocks return to 0 after a select change. In slave mode they check that synchronized strobes never last longer than one cycle. Other behaviours can only be shown by the bench scenarios: the full frame period measured end to end, 64 bit clock edges per frame in both ratios, the exact delay to the first frame edge after a restart, the pass-through in slave mode, and the strobe latency after an external edge.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  typedef struct packed {
    logic ratio;
    logic master;
  } clk_mode_t;

  localparam clk_mode_t MODE_AFTER_RESET = '{ratio: 1'b0, master: 1'b1};
endpackage

// File: rtl/aclk_bit_div.sv
module aclk_bit_div #(
  parameter int HALF_LO = 2,
  parameter int HALF_HI = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ratio,
  output logic bclk,
  output logic rise_stb,
  output logic fall_stb,
  output logic fall_evt
);
  localparam int CW = $clog2(HALF_HI + 1);
  localparam logic [CW-1:0] LO_LAST = CW'(HALF_LO - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(HALF_HI - 1);

  logic [CW-1:0] cnt_q;
  logic          term;

  assign term     = (cnt_q == (ratio ? HI_LAST : LO_LAST));
  assign fall_evt = term & bclk & ~clr;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q    <= '0;
      bclk     <= 1'b0;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end else if (term) begin
      cnt_q    <= '0;
      bclk     <= ~bclk;
      rise_stb <= ~bclk;
      fall_stb <= bclk;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
      rise_stb <= 1'b0;
      fall_stb <= 1'b0;
    end
  end

  // R6
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb && fall_stb));
endmodule

// File: rtl/aclk_frame_div.sv
module aclk_frame_div #(
  parameter int SLOTS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic fall_evt,
  output logic lrclk,
  output logic half_stb,
  output logic frame_stb
);
  localparam int SW = $clog2(SLOTS);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

  logic [SW-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      slot_q    <= '0;
      lrclk     <= 1'b0;
      half_stb  <= 1'b0;
      frame_stb <= 1'b0;
    end else if (fall_evt) begin
      if (slot_q == SLOT_LAST) begin
        slot_q    <= '0;
        lrclk     <= ~lrclk;
        half_stb  <= 1'b1;
        frame_stb <= lrclk;
      end else begin
        slot_q    <= slot_q + 1'b1;
        half_stb  <= 1'b0;
        frame_stb <= 1'b0;
      end
    end else begin
      half_stb  <= 1'b0;
      frame_stb <= 1'b0;
    end
  end

  // R6
  frame_in_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb |-> half_stb);
endmodule

// File: rtl/aclk_edge_sync.sv
module aclk_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_stb,
  output logic fall_stb
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_stb = sync_q[STAGES-1] & ~prev_q;
  assign fall_stb = ~sync_q[STAGES-1] & prev_q;

  // R9
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> !rise_stb);
  // R9
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !fall_stb);
endmodule

// File: rtl/audio_clk_div.sv
module audio_clk_div
  import aclk_pkg::*;
#(
  parameter int HALF_LO     = 2,
  parameter int HALF_HI     = 3,
  parameter int SLOTS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ratio_sel,
  input  logic master_en,
  input  logic ext_bclk,
  input  logic ext_lrclk,
  output logic bclk,
  output logic lrclk,
  output logic bclk_rise_stb,
  output logic bclk_fall_stb,
  output logic lr_edge_stb,
  output logic frame_stb
);
  localparam int RW = $clog2(4 * SLOTS * HALF_HI + 1);
  localparam int NEXT = 2;

  clk_mode_t mode_q;
  logic      restart, hold;
  logic      m_bclk, m_rise, m_fall, m_fall_evt;
  logic      m_lrclk, m_half, m_frame;
  logic [NEXT-1:0] ext_vec, s_rise, s_fall;

  assign restart = (ratio_sel != mode_q.ratio) || (master_en != mode_q.master);
  assign hold    = restart || !master_en;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= MODE_AFTER_RESET;
    else        mode_q <= '{ratio: ratio_sel, master: master_en};
  end

  aclk_bit_div #(.HALF_LO(HALF_LO), .HALF_HI(HALF_HI)) u_bit (
    .clk(clk), .rst_n(rst_n), .clr(hold), .ratio(ratio_sel),
    .bclk(m_bclk), .rise_stb(m_rise), .fall_stb(m_fall), .fall_evt(m_fall_evt)
  );

  aclk_frame_div #(.SLOTS(SLOTS)) u_frame (
    .clk(clk), .rst_n(rst_n), .clr(hold), .fall_evt(m_fall_evt),
    .lrclk(m_lrclk), .half_stb(m_half), .frame_stb(m_frame)
  );

  assign ext_vec = {ext_lrclk, ext_bclk};

  for (genvar i = 0; i < NEXT; i++) begin : g_sync
    aclk_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(ext_vec[i]),
      .rise_stb(s_rise[i]), .fall_stb(s_fall[i])
    );
  end

  always_comb begin
    if (master_en) begin
      bclk          = m_bclk;
      lrclk         = m_lrclk;
      bclk_rise_stb = m_rise;
      bclk_fall_stb = m_fall;
      lr_edge_stb   = m_half;
      frame_stb     = m_frame;
    end else begin
      bclk          = ext_bclk;
      lrclk         = ext_lrclk;
      bclk_rise_stb = s_rise[0];
      bclk_fall_stb = s_fall[0];
      lr_edge_stb   = s_rise[1] | s_fall[1];
      frame_stb     = s_fall[1];
    end
  end

  // Checker state: run lengths of the generated clocks
  logic          restart_q, bclk_d, lr_d;
  logic [RW-1:0] brun_q, lrun_q, brun_c, lrun_c, exp_half, exp_lr;

  assign brun_c   = (restart_q || m_bclk != bclk_d) ? RW'(1) : brun_q + 1'b1;
  assign lrun_c   = (restart_q || m_lrclk != lr_d) ? RW'(1) : lrun_q + 1'b1;
  assign exp_half = mode_q.ratio ? RW'(HALF_HI) : RW'(HALF_LO);
  assign exp_lr   = mode_q.ratio ? RW'(2 * SLOTS * HALF_HI) : RW'(2 * SLOTS * HALF_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      restart_q <= 1'b0;
      bclk_d    <= 1'b0;
      lr_d      <= 1'b0;
      brun_q    <= '0;
      lrun_q    <= '0;
    end else begin
      restart_q <= restart;
      bclk_d    <= m_bclk;
      lr_d      <= m_lrclk;
      brun_q    <= brun_c;
      lrun_q    <= lrun_c;
    end
  end

  // R2, R3
  bclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.master && !restart_q && m_bclk != bclk_d) |-> (brun_q == exp_half));
  // R4
  lr_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q.master && !restart_q && m_lrclk != lr_d) |-> (lrun_q == exp_lr));
  // R5
  lr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_q && m_lrclk != lr_d) |-> (!m_bclk && bclk_d));
  // R6
  rise_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rise |-> (m_bclk && !bclk_d));
  // R6
  frame_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_frame |-> (!m_lrclk && lr_d));
  // R7
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!m_bclk && !m_lrclk));
endmodule

// File: tb/sim_audio_clk_div.sv
`timescale 1ns/1ps
module sim_audio_clk_div;
  logic clk = 1'b0;
  logic rst_n, ratio_sel, master_en, ext_bclk, ext_lrclk;
  logic bclk, lrclk, bclk_rise_stb, bclk_fall_stb, lr_edge_stb, frame_stb;

  always #2.5 clk = ~clk;

  audio_clk_div u0 (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ratio_sel), .master_en(master_en),
    .ext_bclk(ext_bclk), .ext_lrclk(ext_lrclk), .bclk(bclk), .lrclk(lrclk),
    .bclk_rise_stb(bclk_rise_stb), .bclk_fall_stb(bclk_fall_stb),
    .lr_edge_stb(lr_edge_stb), .frame_stb(frame_stb)
  );

  typedef struct {
    int    lr_per;
    int    rises;
    int    bper;
    string req;
  } exp_t;

  exp_t expq[$];
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  bit   armed = 1'b0, arm_req = 1'b0, started = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: measures periods and strobes, pops expected items
  initial begin
    int cyc, last_lr, last_br, rises, bper, bad_stb, bad_al;
    logic p_lr, p_b;
    exp_t e;
    cyc = 0; last_lr = 0; last_br = -1; rises = 0; bper = 0; bad_stb = 0; bad_al = 0;
    p_lr = 1'b0; p_b = 1'b0;
    forever begin
      @(negedge clk);
      if (arm_req) begin
        p_lr = lrclk; p_b = bclk; armed = 1'b1; arm_req = 1'b0; started = 1'b0;
        cyc = 0; last_br = -1; rises = 0; bad_stb = 0; bad_al = 0;
      end else if (armed) begin
        cyc++;
        if (bclk && !p_b) begin
          if (last_br >= 0) bper = cyc - last_br;
          last_br = cyc;
          rises++;
        end
        if (bclk_rise_stb !== (bclk && !p_b)) bad_stb++;
        if (bclk_fall_stb !== (!bclk && p_b)) bad_stb++;
        if (lr_edge_stb !== (lrclk != p_lr)) bad_stb++;
        if (frame_stb !== (!lrclk && p_lr)) bad_stb++;
        if ((lrclk != p_lr) && !(!bclk && p_b)) bad_al++;
        if (lrclk && !p_lr) begin
          if (started && expq.size() > 0) begin
            e = expq.pop_front();
            check(cyc - last_lr == e.lr_per, {e.req, " frame period"}, cyc - last_lr, e.lr_per);
            check(bper == e.bper, {e.req, " bit clock period"}, bper, e.bper);
            check(rises == e.rises, "R4 bit edges per frame", rises, e.rises);
            check(bad_al == 0, "R5 frame edge on bit fall", bad_al, 0);
            check(bad_stb == 0, "R6 strobe mismatches", bad_stb, 0);
          end
          started = 1'b1; last_lr = cyc; rises = 0; bad_stb = 0; bad_al = 0;
        end
        p_lr = lrclk; p_b = bclk;
      end
    end
  end

  // Driver: switch to master mode, check restart, push expected frames
  task automatic run_master(input logic r, input int nfr);
    int h, cnt, k;
    exp_t e;
    h = r ? 3 : 2;
    armed = 1'b0;
    @(negedge clk);
    ratio_sel = r; master_en = 1'b1;
    @(negedge clk);
    check(bclk == 1'b0 && lrclk == 1'b0, "R7 clocks cleared", {bclk, lrclk}, 0);
    cnt = 0;
    while (lrclk !== 1'b1 && cnt < 2000) begin
      cnt++;
      @(negedge clk);
    end
    check(cnt == 64 * h, "R7 first frame rise", cnt, 64 * h);
    for (int i = 0; i < nfr; i++) begin
      e.lr_per = 128 * h; e.rises = 64; e.bper = 2 * h; e.req = r ? "R3" : "R2";
      expq.push_back(e);
    end
    arm_req = 1'b1;
    k = 0;
    while (expq.size() > 0 && k < (nfr + 3) * 400) begin
      k++;
      @(negedge clk);
    end
    check(expq.size() == 0, r ? "R3 scoreboard drained" : "R2 scoreboard drained", expq.size(), 0);
    expq.delete();
    armed = 1'b0;
  endtask

  // Slave: drive one external edge, count the matching strobe
  task automatic slave_edge(input bit on_lr, input logic val, input string req);
    int first4, total;
    logic s;
    @(negedge clk);
    if (on_lr) ext_lrclk = val; else ext_bclk = val;
    #1;
    check(bclk === ext_bclk && lrclk === ext_lrclk, "R8 pass-through", {bclk, lrclk}, {ext_bclk, ext_lrclk});
    first4 = 0; total = 0;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (!on_lr) s = val ? bclk_rise_stb : bclk_fall_stb;
      else        s = val ? lr_edge_stb : frame_stb;
      if (s) begin
        total++;
        if (i <= 4) first4++;
      end
    end
    check(first4 == 1 && total == 1, req, total, 1);
  endtask

  initial begin
    rst_n = 1'b0; ratio_sel = 1'b0; master_en = 1'b1; ext_bclk = 1'b0; ext_lrclk = 1'b0;
    repeat (3) @(negedge clk);
    check({bclk, lrclk, bclk_rise_stb, bclk_fall_stb, lr_edge_stb, frame_stb} == 6'b0,
          "R1 reset outputs", {bclk, lrclk, bclk_rise_stb, bclk_fall_stb, lr_edge_stb, frame_stb}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    run_master(1'b1, 3);
    run_master(1'b0, 3);
    @(negedge clk);
    master_en = 1'b0;
    repeat (4) @(negedge clk);
    slave_edge(1'b0, 1'b1, "R9 bit rise strobe");
    slave_edge(1'b0, 1'b0, "R9 bit fall strobe");
    slave_edge(1'b1, 1'b1, "R9 frame edge strobe");
    slave_edge(1'b1, 1'b0, "R9 frame start strobe");
    run_master(1'b1, 2);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule